// File: doc/BRIEF.md
# Outbound Window Address Translator

This block maps processor-side addresses that land in a fixed outbound memory region onto 64-bit PCIe bus addresses. The region starting at `BASE` is split into 32 equal windows. A single 3-bit size index N, shared by every window, sets each window to 2^N megabytes. Every window has a low and a high translation register. Bit 0 of the low register enables that window. A bit in a command register enables translation as a whole.

A register write port loads the size, command and window registers. A separate read port returns their contents one cycle after the read address is presented. On the lookup path, a request address presented with `req_valid` produces a registered response one cycle later. The response is either a hit carrying the translated address, or a miss that carries an all-zero address.

The response side is a three-state machine that advances on every clock. RS_IDLE means no response is present. RS_HIT means a translated address is on the output. RS_MISS means the request failed. From any state, a cycle without `req_valid` moves to RS_IDLE. A request that resolves to an enabled window moves to RS_HIT. Any other request moves to RS_MISS.

Top module: `ob_window_xlat`

## Requirements
- R1: After reset, `rsp_hit` and `rsp_miss` are low and every register reads zero.
- R2: The read port presents the register value one cycle after `rd_addr`. Window n's low register is at 0x200+8n and its high register at 0x204+8n; both read back the full 32 written bits. The size register at 0x030 reads back only bits [2:0]. The command register at 0x004 reads back only bit 1. Any other address reads zero.
- R3: Exactly one of `rsp_hit` and `rsp_miss` is high in the cycle after a cycle with `req_valid` high. Both are low after a cycle with `req_valid` low.
- R4: The selected window is (req_addr − BASE) >> (20 + N), where N is size register bits [2:0].
- R5: On a hit, `rsp_addr` equals {high register, low register with bits below 20+N cleared}, with the in-window offset bits ((req_addr − BASE) masked to 20+N bits) OR'd into those cleared bits.
- R6: With command register bit 1 clear, every request misses.
- R7: A request to a window whose low register bit 0 is clear misses.
- R8: A request below BASE, or one whose window index is 32 or more, misses.
- R9: On a miss, `rsp_addr` is zero.
- R10: A register write in the same cycle as a request does not affect that request; the lookup uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Register read data, one cycle after rd_addr |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Processor-side address to translate |
| rsp_hit | output | 1 | Translation succeeded (registered) |
| rsp_miss | output | 1 | Translation failed (registered) |
| rsp_addr | output | 64 | Translated bus address, zero on miss |

## Verification
The hardest case to reach is the top of the window span. This is an address one window past the last window, and whether it is in range depends on the size index. The bench reprograms all eight size values and computes, for each one, a probe at BASE + 32·2^(20+N) whenever that address still fits in 32 bits, alongside a probe in every window. The write-during-lookup case of R10 needs a write and a request in the same cycle, so the bench drives both strobes together on one falling edge.

// File: rtl/obw_pkg.sv
package obw_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HIT  = 2'd1,
        RS_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/obw_regs.sv
module obw_regs #(
    parameter int              NUM_WIN  = 32,
    parameter int              AW       = 12,
    parameter int              DW       = 32,
    parameter int              SIZE_W   = 3,
    parameter int              EN_BIT   = 1,
    parameter logic [AW-1:0]   OFF_CMD  = 12'h004,
    parameter logic [AW-1:0]   OFF_SIZE = 12'h030,
    parameter logic [AW-1:0]   OFF_WIN  = 12'h200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic [AW-1:0]                 rd_addr,
    output logic [DW-1:0]                 rd_data,
    output logic [SIZE_W-1:0]             size_idx,
    output logic                          glob_en,
    output logic [NUM_WIN-1:0][DW-1:0]    win_lo,
    output logic [NUM_WIN-1:0][DW-1:0]    win_hi
);

    localparam int            IDX_W   = $clog2(NUM_WIN);
    localparam logic [AW-1:0] WIN_END = OFF_WIN + AW'(8 * NUM_WIN);

    // write decode
    logic [AW-1:0]    wr_rel;
    logic             wr_in_win;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_upper;

    always_comb begin
        wr_rel    = wr_addr - OFF_WIN;
        wr_in_win = (wr_addr >= OFF_WIN) && (wr_addr < WIN_END) && (wr_addr[1:0] == 2'b00);
        wr_idx    = wr_rel[IDX_W+2:3];
        wr_upper  = wr_rel[2];
    end

    // global registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_idx <= '0;
            glob_en  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == OFF_SIZE)
                size_idx <= wr_data[SIZE_W-1:0];
            if (wr_addr == OFF_CMD)
                glob_en <= wr_data[EN_BIT];
        end
    end

    // per-window offset registers
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_lo[w] <= '0;
                win_hi[w] <= '0;
            end else if (wr_en && wr_in_win && (wr_idx == IDX_W'(w))) begin
                if (wr_upper)
                    win_hi[w] <= wr_data;
                else
                    win_lo[w] <= wr_data;
            end
        end
    end

    // read decode and registered read data
    logic [AW-1:0]    rd_rel;
    logic             rd_in_win;
    logic [IDX_W-1:0] rd_idx;
    logic [DW-1:0]    rd_next;

    always_comb begin
        rd_rel    = rd_addr - OFF_WIN;
        rd_in_win = (rd_addr >= OFF_WIN) && (rd_addr < WIN_END) && (rd_addr[1:0] == 2'b00);
        rd_idx    = rd_rel[IDX_W+2:3];
        rd_next   = '0;
        if (rd_addr == OFF_SIZE)
            rd_next[SIZE_W-1:0] = size_idx;
        else if (rd_addr == OFF_CMD)
            rd_next[EN_BIT] = glob_en;
        else if (rd_in_win)
            rd_next = rd_rel[2] ? win_hi[rd_idx] : win_lo[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= rd_next;
    end

endmodule

// File: rtl/obw_index.sv
module obw_index #(
    parameter int               NUM_WIN  = 32,
    parameter int               ADDR_W   = 32,
    parameter int               SIZE_W   = 3,
    parameter int               MB_SHIFT = 20,
    parameter logic [ADDR_W-1:0] BASE    = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [SIZE_W-1:0]          size_idx,
    output logic [$clog2(NUM_WIN)-1:0] idx,
    output logic                       in_span,
    output logic [ADDR_W-1:0]          offset,
    output logic [ADDR_W-1:0]          keep_mask
);

    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int SH_W  = $clog2(ADDR_W) + 1;

    logic [SH_W-1:0]   shift_amt;
    logic [ADDR_W-1:0] quot;
    logic              below;

    always_comb begin
        below     = addr < BASE;
        offset    = addr - BASE;
        shift_amt = SH_W'(MB_SHIFT) + SH_W'(size_idx);
        quot      = offset >> shift_amt;
        keep_mask = (ADDR_W'(1) << shift_amt) - ADDR_W'(1);
        in_span   = !below && (quot < ADDR_W'(NUM_WIN));
        idx       = quot[IDX_W-1:0];
    end

endmodule

// File: rtl/obw_compose.sv
module obw_compose #(
    parameter int NUM_WIN = 32,
    parameter int ADDR_W  = 32
) (
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_lo,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_hi,
    input  logic [$clog2(NUM_WIN)-1:0]     idx,
    input  logic                           in_span,
    input  logic                           glob_en,
    input  logic [ADDR_W-1:0]              offset,
    input  logic [ADDR_W-1:0]              keep_mask,
    output logic                           hit,
    output logic [2*ADDR_W-1:0]            xaddr
);

    logic [ADDR_W-1:0] sel_lo;
    logic [ADDR_W-1:0] sel_hi;

    always_comb begin
        sel_lo = win_lo[idx];
        sel_hi = win_hi[idx];
        hit    = glob_en && in_span && sel_lo[0];
        xaddr  = {sel_hi, (sel_lo & ~keep_mask) | (offset & keep_mask)};
    end

endmodule

// File: rtl/ob_window_xlat.sv
module ob_window_xlat
    import obw_pkg::*;
#(
    parameter int                NUM_WIN  = 32,
    parameter int                AW       = 12,
    parameter int                ADDR_W   = 32,
    parameter int                SIZE_W   = 3,
    parameter int                MB_SHIFT = 20,
    parameter logic [ADDR_W-1:0] BASE     = 32'h2000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [ADDR_W-1:0]   wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [ADDR_W-1:0]   rd_data,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic [2*ADDR_W-1:0] rsp_addr
);

    localparam int IDX_W = $clog2(NUM_WIN);

    logic [SIZE_W-1:0]               size_idx;
    logic                            glob_en;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_lo;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_hi;
    logic [IDX_W-1:0]                win_idx;
    logic                            in_span;
    logic [ADDR_W-1:0]               win_off;
    logic [ADDR_W-1:0]               keep_mask;
    logic                            look_hit;
    logic [2*ADDR_W-1:0]             look_addr;

    obw_regs #(
        .NUM_WIN (NUM_WIN),
        .AW      (AW),
        .DW      (ADDR_W),
        .SIZE_W  (SIZE_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .size_idx (size_idx),
        .glob_en  (glob_en),
        .win_lo   (win_lo),
        .win_hi   (win_hi)
    );

    obw_index #(
        .NUM_WIN  (NUM_WIN),
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .MB_SHIFT (MB_SHIFT),
        .BASE     (BASE)
    ) u_index (
        .addr      (req_addr),
        .size_idx  (size_idx),
        .idx       (win_idx),
        .in_span   (in_span),
        .offset    (win_off),
        .keep_mask (keep_mask)
    );

    obw_compose #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W)
    ) u_compose (
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .idx       (win_idx),
        .in_span   (in_span),
        .glob_en   (glob_en),
        .offset    (win_off),
        .keep_mask (keep_mask),
        .hit       (look_hit),
        .xaddr     (look_addr)
    );

    rsp_state_e state_q;
    rsp_state_e state_d;

    always_comb begin
        state_d = RS_IDLE;
        unique case (state_q)
            RS_IDLE, RS_HIT, RS_MISS: begin
                if (!req_valid)
                    state_d = RS_IDLE;
                else if (look_hit)
                    state_d = RS_HIT;
                else
                    state_d = RS_MISS;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RS_IDLE;
            rsp_addr <= '0;
        end else begin
            state_q  <= state_d;
            rsp_addr <= (req_valid && look_hit) ? look_addr : '0;
        end
    end

    always_comb begin
        rsp_hit  = 1'b0;
        rsp_miss = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HIT:  rsp_hit  = 1'b1;
            RS_MISS: rsp_miss = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/obw_chk.sv
module obw_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                AW       = 12,
    parameter int                MB_SHIFT = 20,
    parameter logic [ADDR_W-1:0] BASE     = 32'h2000_0000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                glob_en,
    input logic [AW-1:0]       rd_addr,
    input logic [ADDR_W-1:0]   rd_data,
    input logic                rsp_hit,
    input logic                rsp_miss,
    input logic [2*ADDR_W-1:0] rsp_addr
);

    logic [ADDR_W-1:0] rel_now;
    assign rel_now = req_addr - BASE;

    // R3
    excl_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss}));

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_hit || rsp_miss));

    // R3
    no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_hit && !rsp_miss));

    // R6
    glob_off_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !glob_en) |=> rsp_miss);

    // R8
    below_base_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr < BASE)) |=> rsp_miss);

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_addr == '0));

    // R5
    low_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_addr[MB_SHIFT-1:0] == $past(rel_now[MB_SHIFT-1:0])));

    // R2
    size_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 12'h030) |=> (rd_data[ADDR_W-1:3] == '0));

endmodule

bind ob_window_xlat obw_chk #(
    .ADDR_W   (ADDR_W),
    .AW       (AW),
    .MB_SHIFT (MB_SHIFT),
    .BASE     (BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .glob_en   (glob_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_addr  (rsp_addr)
);

// File: tb/ob_window_xlat_bench.sv
`timescale 1ns/1ps
module ob_window_xlat_bench;

    localparam logic [31:0] BASE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_hit;
    logic        rsp_miss;
    logic [63:0] rsp_addr;

    int n_tests = 0;
    int n_fail  = 0;
    logic glob  = 1'b0;

    always #2 clk = ~clk;

    ob_window_xlat #(.BASE(BASE)) u_ob_window_xlat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_addr  (rsp_addr)
    );

    function automatic logic win_en(int n);
        return (n % 7) != 4;
    endfunction

    function automatic logic [31:0] lo_val(int n);
        logic [31:0] v;
        v = 32'h9000_0000 + 32'(n) * 32'h0123_4567;
        return {v[31:1], win_en(n)};
    endfunction

    function automatic logic [31:0] hi_val(int n);
        return 32'hA000_0000 + 32'(n);
    endfunction

    function automatic logic [63:0] exp_xl(int n, int sz, logic [31:0] off);
        logic [31:0] m;
        m = (32'd1 << (20 + sz)) - 32'd1;
        return {hi_val(n), (lo_val(n) & ~m) | (off & m)};
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        rd_addr = a;
        @(negedge clk);
        check64(tag, {32'd0, rd_data}, {32'd0, exp});
    endtask

    task automatic req_chk(string tag, logic [31:0] a, logic exp_hit, logic [63:0] exp_addr);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check64({tag, " flags"}, {62'd0, rsp_hit, rsp_miss}, {62'd0, exp_hit, !exp_hit});
        check64({tag, " addr"}, rsp_addr, exp_hit ? exp_addr : 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check64("R1 flags", {62'd0, rsp_hit, rsp_miss}, 64'd0);
        rd_chk("R1 size", 12'h030, 32'd0);
        rd_chk("R1 cmd", 12'h004, 32'd0);
        rd_chk("R1 lo0", 12'h200, 32'd0);
        rd_chk("R1 hi31", 12'h2FC, 32'd0);

        // program windows
        for (int n = 0; n < 32; n++) begin
            wr(12'(12'h200 + 8 * n), lo_val(n));
            wr(12'(12'h204 + 8 * n), hi_val(n));
        end
        wr(12'h004, 32'hFFFF_FFFF);
        glob = 1'b1;
        wr(12'h030, 32'hFFFF_FFF8);

        // R2: read back
        for (int n = 0; n < 32; n++) begin
            rd_chk("R2 lo", 12'(12'h200 + 8 * n), lo_val(n));
            rd_chk("R2 hi", 12'(12'h204 + 8 * n), hi_val(n));
        end
        rd_chk("R2 cmd", 12'h004, 32'h0000_0002);
        rd_chk("R2 size0", 12'h030, 32'd0);
        wr(12'h030, 32'hFFFF_FFFD);
        rd_chk("R2 size5", 12'h030, 32'd5);
        rd_chk("R2 unmapped", 12'h100, 32'd0);
        rd_chk("R2 past windows", 12'h300, 32'd0);

        // R3: idle cycle gives no response
        @(negedge clk);
        check64("R3 idle", {62'd0, rsp_hit, rsp_miss}, 64'd0);

        // R4 R5 R7 R8 sweep over every size and window
        for (int sz = 0; sz < 8; sz++) begin
            logic [63:0] win;
            wr(12'h030, 32'(sz));
            win = 64'd1 << (20 + sz);
            for (int n = 0; n < 32; n++) begin
                logic [63:0] a64;
                logic [31:0] off;
                off = (32'(n) * 32'h0001_3579 + 32'(sz) * 32'h0000_0ACE) & 32'(win - 64'd1);
                a64 = {32'd0, BASE} + 64'(n) * win + {32'd0, off};
                if (a64 <= 64'hFFFF_FFFF)
                    req_chk(win_en(n) ? "R4 R5 window" : "R7 disabled window",
                            a64[31:0], win_en(n), exp_xl(n, sz, off));
            end
            if ({32'd0, BASE} + 64'd32 * win <= 64'hFFFF_FFFF)
                req_chk("R8 past span", 32'(BASE + 32'(64'd32 * win)), 1'b0, 64'd0);
            req_chk("R8 below base", BASE - 32'd1, 1'b0, 64'd0);
            req_chk("R8 zero addr", 32'd0, 1'b0, 64'd0);
        end

        // R6: global enable clear
        wr(12'h030, 32'd2);
        wr(12'h004, 32'd0);
        glob = 1'b0;
        req_chk("R6 global off", BASE + 32'h0040_0123, 1'b0, 64'd0);
        wr(12'h004, 32'h0000_0002);
        glob = 1'b1;
        req_chk("R6 global on", BASE + 32'h0040_0123, 1'b1, exp_xl(1, 2, 32'h0000_0123));

        // R10: write and request in the same cycle
        wr_en = 1'b1; wr_addr = 12'h200; wr_data = lo_val(0) & 32'hFFFF_FFFE;
        req_valid = 1'b1; req_addr = BASE + 32'h0000_0456;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check64("R10 flags", {62'd0, rsp_hit, rsp_miss}, 64'd2);
        check64("R10 addr", rsp_addr, exp_xl(0, 2, 32'h0000_0456));
        req_chk("R10 after write", BASE + 32'h0000_0456, 1'b0, 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule